// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block turns a CPU physical address into an address on a wider bus, such as a 64-bit PCI address space, using a small set of programmable outbound windows. Software programs each window through a write-only register port. Each window has a page base (CPU address shifted right by 12), a translation target split into a 32-bit low part and a 20-bit extended part, and an attribute word. The attribute word carries an enable, a size code and a transaction type.

A lookup presents a CPU address for one cycle. One cycle later the block returns four things: the translated bus address, a flag that marks the transaction as I/O rather than memory, the number of the winning window, and a miss flag. Windows are power-of-two sized and naturally aligned, with a 4 KiB minimum. Slot 0 is a built-in fallback that cannot be programmed. When no window hits, the address passes through unchanged as a memory access.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every programmable window is disabled and `rsp_valid` is 0, so every lookup misses until a window is enabled.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `lk_valid` high. The response fields change only after a lookup.
- R3: A window hits when attribute bit 31 is set and the lookup address bits at and above the window size equal the same bits of `base << 12`. On a hit, the bus address takes the lookup address bits below the size and the target bits above it. The target is `{ext[19:0], tgt[31:0], 12'b0}`, so the result is 64 bits.
- R4: When several windows hit, the lowest-numbered one is reported in `rsp_win` and supplies the address.
- R5: When no window hits, `rsp_miss` is 1, `rsp_win` is 0, `rsp_io` is 0 and `rsp_addr` is the lookup address zero-extended to 64 bits.
- R6: Writes addressed to slot 0, or to a slot number of `NUM_WIN` or above, change nothing that any lookup can observe.
- R7: Writing an attribute word with bit 31 clear disables that window at once for later lookups.
- R8: Attribute bits [5:0] hold log2(size) minus 1. Codes below 11 behave as a 4 KiB window.
- R9: Attribute bits [15:12] equal to 8 (for example 0x00088000) mark an I/O window and set `rsp_io` on a hit. Any other value, such as 0x00044000, marks a memory window.
- R10: A lookup in the same cycle as a register write uses the configuration as it was before that write.
- R11: Register select codes: 0 writes the page base from data bits [19:0], 1 writes the target low word, 2 writes the extended target from data bits [19:0], 3 writes the attribute word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Slot number of the write |
| cfg_sel | input | 2 | Register select within the slot |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | CPU physical address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the lookup |
| rsp_addr | output | 64 | Translated bus address |
| rsp_io | output | 1 | 1 for an I/O transaction, 0 for memory |
| rsp_win | output | 3 | Winning slot, 0 when the fallback is used |
| rsp_miss | output | 1 | No programmable window hit |

## Verification
A register write and a lookup can land in the same cycle. The lookup must then see the old window set. The bench provokes this in two ways. First, it enables a window in the very cycle that it looks up an address inside that window, and expects a miss followed by a hit on the next lookup. Second, a long random phase mixes writes and lookups freely. The bench's own model resolves each lookup before it applies that cycle's write, and compares the result with every response.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_TGT  = 2'd1,
      SEL_TGTX = 2'd2,
      SEL_ATTR = 2'd3
   } reg_sel_e;

   localparam int ATTR_EN_BIT = 31;
   localparam int ATTR_TY_LSB = 12;
   localparam int TY_W        = 4;
   localparam int SZ_W        = 6;
   localparam logic [TY_W-1:0] TY_IO = 4'h8;

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
   import obwin_pkg::*;
#(
   parameter int NUM_WIN = 5,
   parameter int DATA_W  = 32,
   parameter int BASE_W  = 20,
   parameter int TGT_W   = 32,
   parameter int EXT_W   = 20,
   parameter int WIN_IW  = 3
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cfg_we,
   input  logic [WIN_IW-1:0]                    cfg_win,
   input  logic [1:0]                           cfg_sel,
   input  logic [DATA_W-1:0]                    cfg_wdata,
   output logic [NUM_WIN-1:1][BASE_W-1:0]       base_q,
   output logic [NUM_WIN-1:1][TGT_W-1:0]        tgt_q,
   output logic [NUM_WIN-1:1][EXT_W-1:0]        tgtx_q,
   output logic [NUM_WIN-1:1]                   en_q,
   output logic [NUM_WIN-1:1][SZ_W-1:0]         code_q,
   output logic [NUM_WIN-1:1][TY_W-1:0]         ty_q
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(cfg_sel);

   // Slot 0 has no storage: it is the fixed fallback.
   for (genvar g = 1; g < NUM_WIN; g++) begin : g_slot
      logic hit_wr;
      assign hit_wr = cfg_we && (cfg_win == WIN_IW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[g] <= '0;
            tgt_q[g]  <= '0;
            tgtx_q[g] <= '0;
            en_q[g]   <= 1'b0;
            code_q[g] <= '0;
            ty_q[g]   <= '0;
         end else if (hit_wr) begin
            case (sel)
               SEL_BASE: base_q[g] <= cfg_wdata[BASE_W-1:0];
               SEL_TGT:  tgt_q[g]  <= cfg_wdata[TGT_W-1:0];
               SEL_TGTX: tgtx_q[g] <= cfg_wdata[EXT_W-1:0];
               SEL_ATTR: begin
                  en_q[g]   <= cfg_wdata[ATTR_EN_BIT];
                  code_q[g] <= cfg_wdata[SZ_W-1:0];
                  ty_q[g]   <= cfg_wdata[ATTR_TY_LSB +: TY_W];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/obwin_match.sv
module obwin_match
   import obwin_pkg::*;
#(
   parameter int CPU_AW = 32,
   parameter int PG_SH  = 12,
   parameter int TGT_W  = 32,
   parameter int EXT_W  = 20,
   localparam int BASE_W = CPU_AW - PG_SH,
   localparam int BUS_AW = EXT_W + TGT_W + PG_SH,
   localparam int EFF_W  = SZ_W + 1
) (
   input  logic [CPU_AW-1:0] lk_addr,
   input  logic [BASE_W-1:0] base,
   input  logic [TGT_W-1:0]  tgt,
   input  logic [EXT_W-1:0]  tgtx,
   input  logic              en,
   input  logic [SZ_W-1:0]   sz_code,
   output logic              hit,
   output logic [BUS_AW-1:0] xaddr
);

   logic [EFF_W-1:0]  eff_sz;
   logic [CPU_AW-1:0] base_full;
   logic [CPU_AW-1:0] keep;
   logic [BUS_AW-1:0] tgt_full;

   assign base_full = {base, {PG_SH{1'b0}}};
   assign tgt_full  = {tgtx, tgt, {PG_SH{1'b0}}};

   // Effective size in address bits, never below the page size.
   always_comb begin
      eff_sz = EFF_W'(sz_code) + EFF_W'(1);
      if (eff_sz < EFF_W'(PG_SH)) eff_sz = EFF_W'(PG_SH);
   end

   always_comb begin
      for (int i = 0; i < CPU_AW; i++) keep[i] = (i >= int'(eff_sz));
   end

   assign hit = en && (((lk_addr ^ base_full) & keep) == '0);

   always_comb begin
      xaddr = tgt_full;
      for (int i = 0; i < CPU_AW; i++) begin
         if (i < int'(eff_sz)) xaddr[i] = lk_addr[i];
      end
   end

endmodule

// File: rtl/obwin_pick.sv
module obwin_pick #(
   parameter int NUM_WIN = 5,
   parameter int BUS_AW  = 64,
   parameter int WIN_IW  = 3
) (
   input  logic [NUM_WIN-1:1]             hit,
   input  logic [NUM_WIN-1:1]             io,
   input  logic [NUM_WIN-1:0][BUS_AW-1:0] xaddr,
   output logic [WIN_IW-1:0]              sel_idx,
   output logic [BUS_AW-1:0]              sel_addr,
   output logic                           sel_io,
   output logic                           sel_miss
);

   // Scan downward so the lowest-numbered hit is the last to be taken.
   always_comb begin
      sel_idx  = '0;
      sel_addr = xaddr[0];
      sel_io   = 1'b0;
      for (int w = NUM_WIN - 1; w >= 1; w--) begin
         if (hit[w]) begin
            sel_idx  = WIN_IW'(w);
            sel_addr = xaddr[w];
            sel_io   = io[w];
         end
      end
   end

   assign sel_miss = ~|hit;

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
   import obwin_pkg::*;
#(
   parameter int NUM_WIN = 5,
   parameter int CPU_AW  = 32,
   parameter int PG_SH   = 12,
   parameter int DATA_W  = 32,
   parameter int TGT_W   = 32,
   parameter int EXT_W   = 20,
   localparam int BASE_W = CPU_AW - PG_SH,
   localparam int BUS_AW = EXT_W + TGT_W + PG_SH,
   localparam int WIN_IW = $clog2(NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [WIN_IW-1:0] cfg_win,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              lk_valid,
   input  logic [CPU_AW-1:0] lk_addr,
   output logic              rsp_valid,
   output logic [BUS_AW-1:0] rsp_addr,
   output logic              rsp_io,
   output logic [WIN_IW-1:0] rsp_win,
   output logic              rsp_miss
);

   if (NUM_WIN < 2) begin : g_bad_nwin
      $error("NUM_WIN must leave at least one programmable slot");
   end
   if (CPU_AW <= PG_SH) begin : g_bad_aw
      $error("CPU_AW must exceed the page shift");
   end
   if (BUS_AW < CPU_AW) begin : g_bad_bus
      $error("bus address must be at least as wide as the CPU address");
   end
   if (DATA_W <= ATTR_EN_BIT || DATA_W < TGT_W || DATA_W < BASE_W || DATA_W < EXT_W) begin : g_bad_dw
      $error("DATA_W too narrow for the register fields");
   end

   logic [NUM_WIN-1:1][BASE_W-1:0] base_q;
   logic [NUM_WIN-1:1][TGT_W-1:0]  tgt_q;
   logic [NUM_WIN-1:1][EXT_W-1:0]  tgtx_q;
   logic [NUM_WIN-1:1]             en_q;
   logic [NUM_WIN-1:1][SZ_W-1:0]   code_q;
   logic [NUM_WIN-1:1][TY_W-1:0]   ty_q;

   logic [NUM_WIN-1:1]             hit_w;
   logic [NUM_WIN-1:1]             io_w;
   logic [NUM_WIN-1:0][BUS_AW-1:0] xaddr_w;

   logic [WIN_IW-1:0] pick_idx;
   logic [BUS_AW-1:0] pick_addr;
   logic              pick_io;
   logic              pick_miss;

   obwin_regs #(
      .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .BASE_W(BASE_W),
      .TGT_W(TGT_W), .EXT_W(EXT_W), .WIN_IW(WIN_IW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .base_q(base_q), .tgt_q(tgt_q), .tgtx_q(tgtx_q),
      .en_q(en_q), .code_q(code_q), .ty_q(ty_q)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      if (g == 0) begin : g_dflt
         assign xaddr_w[g] = BUS_AW'(lk_addr);
      end else begin : g_prog
         obwin_match #(
            .CPU_AW(CPU_AW), .PG_SH(PG_SH), .TGT_W(TGT_W), .EXT_W(EXT_W)
         ) u_match (
            .lk_addr(lk_addr), .base(base_q[g]), .tgt(tgt_q[g]), .tgtx(tgtx_q[g]),
            .en(en_q[g]), .sz_code(code_q[g]),
            .hit(hit_w[g]), .xaddr(xaddr_w[g])
         );
         assign io_w[g] = (ty_q[g] == TY_IO);
      end
   end

   obwin_pick #(
      .NUM_WIN(NUM_WIN), .BUS_AW(BUS_AW), .WIN_IW(WIN_IW)
   ) u_pick (
      .hit(hit_w), .io(io_w), .xaddr(xaddr_w),
      .sel_idx(pick_idx), .sel_addr(pick_addr), .sel_io(pick_io), .sel_miss(pick_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_io    <= 1'b0;
         rsp_win   <= '0;
         rsp_miss  <= 1'b0;
      end else begin
         rsp_valid <= lk_valid;
         if (lk_valid) begin
            rsp_addr <= pick_addr;
            rsp_io   <= pick_io;
            rsp_win  <= pick_idx;
            rsp_miss <= pick_miss;
         end
      end
   end

endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk #(
   parameter int NUM_WIN = 5,
   parameter int CPU_AW  = 32,
   parameter int BUS_AW  = 64,
   parameter int WIN_IW  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [CPU_AW-1:0] lk_addr,
   input logic              rsp_valid,
   input logic [BUS_AW-1:0] rsp_addr,
   input logic              rsp_io,
   input logic [WIN_IW-1:0] rsp_win,
   input logic              rsp_miss
);

   // R2: response strobe trails the request by one cycle
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   // R2: fields hold while no lookup is presented
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> $stable(rsp_addr) && $stable(rsp_win) && $stable(rsp_miss));
   // R5: fallback passes the address through as memory from slot 0
   a_r5_identity: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rsp_miss || (rsp_addr == BUS_AW'($past(lk_addr))
                                  && rsp_win == '0 && !rsp_io)));
   // R3: page offset always passes through untouched
   a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_addr[11:0] == $past(lk_addr[11:0]));
   // R4: a hit names a programmable slot that exists
   a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> (rsp_win != '0 && int'(rsp_win) < NUM_WIN));

endmodule

bind obwin_xlate obwin_xlate_chk #(
   .NUM_WIN(NUM_WIN), .CPU_AW(CPU_AW), .BUS_AW(BUS_AW), .WIN_IW(WIN_IW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_io(rsp_io),
   .rsp_win(rsp_win), .rsp_miss(rsp_miss)
);

// File: tb/obwin_xlate_tb.sv
`timescale 1ns/1ps
module obwin_xlate_tb;

   localparam int NW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_win = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        rsp_valid;
   logic [63:0] rsp_addr;
   logic        rsp_io;
   logic [2:0]  rsp_win;
   logic        rsp_miss;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   obwin_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_io(rsp_io), .rsp_win(rsp_win), .rsp_miss(rsp_miss)
   );

   // ---------------- behavioural reference ----------------
   logic [19:0] m_base [NW];
   logic [31:0] m_tgt  [NW];
   logic [19:0] m_ext  [NW];
   logic        m_en   [NW];
   int          m_code [NW];
   logic        m_io   [NW];

   logic        e_valid = 1'b0;
   logic [63:0] e_addr  = '0;
   logic        e_io    = 1'b0;
   int          e_win   = 0;
   logic        e_miss  = 1'b0;

   function automatic void model_lookup(input logic [31:0] a, output logic [63:0] xa,
                                        output logic io, output logic miss, output int win);
      xa = {32'h0, a}; io = 1'b0; miss = 1'b1; win = 0;
      for (int w = 1; w < NW; w++) begin
         int sz = m_code[w] + 1;
         longint unsigned bse, msk, tg;
         if (sz < 12) sz = 12;
         if (sz > 32) sz = 32;
         bse = longint'(m_base[w]) << 12;
         if (miss && m_en[w] && ((longint'(a) >> sz) == (bse >> sz))) begin
            msk  = (64'd1 << sz) - 64'd1;
            tg   = {m_ext[w], m_tgt[w], 12'h000};
            xa   = (tg & ~msk) | (longint'(a) & msk);
            io   = m_io[w];
            miss = 1'b0;
            win  = w;
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NW; w++) begin
            m_base[w] = '0; m_tgt[w] = '0; m_ext[w] = '0;
            m_en[w] = 1'b0; m_code[w] = 0; m_io[w] = 1'b0;
         end
         e_valid = 1'b0; e_addr = '0; e_io = 1'b0; e_win = 0; e_miss = 1'b0;
      end else begin
         // R10: lookup sees configuration before this cycle's write
         e_valid = lk_valid;
         if (lk_valid) model_lookup(lk_addr, e_addr, e_io, e_miss, e_win);
         if (cfg_we && cfg_win >= 1 && cfg_win < NW) begin
            case (cfg_sel)
               2'd0: m_base[cfg_win] = cfg_wdata[19:0];
               2'd1: m_tgt[cfg_win]  = cfg_wdata;
               2'd2: m_ext[cfg_win]  = cfg_wdata[19:0];
               default: begin
                  m_en[cfg_win]   = cfg_wdata[31];
                  m_code[cfg_win] = int'(cfg_wdata[5:0]);
                  m_io[cfg_win]   = (cfg_wdata[15:12] == 4'h8);
               end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (rsp_valid !== e_valid ||
             (e_valid && (rsp_addr !== e_addr || rsp_io !== e_io ||
                          int'(rsp_win) != e_win || rsp_miss !== e_miss))) begin
            fails++;
            $display("FAIL %s model: got v=%b a=%h io=%b w=%0d m=%b exp v=%b a=%h io=%b w=%0d m=%b",
                     cur_req, rsp_valid, rsp_addr, rsp_io, rsp_win, rsp_miss,
                     e_valid, e_addr, e_io, e_win, e_miss);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int win, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_win = 3'(win); cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic lookup_expect(input logic [31:0] a, input logic [63:0] ea, input logic eio,
                                input logic emiss, input int ewin, input string req);
      @(negedge clk);
      cur_req = req;
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(rsp_valid === 1'b1, req, 64'(rsp_valid), 64'd1);
      chk(rsp_addr === ea, req, rsp_addr, ea);
      chk(rsp_io === eio && rsp_miss === emiss && int'(rsp_win) == ewin, req,
          {rsp_io, rsp_miss, 59'(rsp_win)}, {eio, emiss, 59'(ewin)});
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rsp_valid === 1'b0, "R1", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      lookup_expect(32'h8123_4567, 64'h0000_0000_8123_4567, 1'b0, 1'b1, 0, "R1");
      @(negedge clk);
      // R2: no lookup, no strobe
      chk(rsp_valid === 1'b0, "R2", 64'(rsp_valid), 64'd0);

      // R11/R3: window 1, 256 MiB memory window
      wr(1, 0, 32'h0008_0000);
      wr(1, 1, 32'h0003_0000);
      wr(1, 2, 32'h000A_BCDE);
      wr(1, 3, 32'h8004_401B);
      lookup_expect(32'h8123_4567, 64'hABCD_E000_3123_4567, 1'b0, 1'b0, 1, "R3");
      lookup_expect(32'h9000_0000, 64'h0000_0000_9000_0000, 1'b0, 1'b1, 0, "R5");

      // R4: overlapping smaller window 2, window 1 still wins
      wr(2, 0, 32'h0008_1234);
      wr(2, 1, 32'h0000_0055);
      wr(2, 3, 32'h8004_400B);
      lookup_expect(32'h8123_4567, 64'hABCD_E000_3123_4567, 1'b0, 1'b0, 1, "R4");

      // R7: disable window 1, window 2 takes over
      wr(1, 3, 32'h0000_0000);
      lookup_expect(32'h8123_4567, 64'h0000_0000_0005_5567, 1'b0, 1'b0, 2, "R7");

      // R8/R9: I/O window with tiny size code clamped to 4 KiB
      wr(3, 0, 32'h0000_0010);
      wr(3, 1, 32'h0000_0777);
      wr(3, 3, 32'h8008_8003);
      lookup_expect(32'h0001_0ABC, 64'h0000_0000_0077_7ABC, 1'b1, 1'b0, 3, "R9");
      lookup_expect(32'h0001_1000, 64'h0000_0000_0001_1000, 1'b0, 1'b1, 0, "R8");

      // R6: slot 0 and out-of-range slots ignore writes
      wr(0, 0, 32'h0000_0020);
      wr(0, 1, 32'h0000_0999);
      wr(0, 3, 32'h8004_401F);
      wr(5, 3, 32'h8004_401F);
      wr(7, 3, 32'h8008_801F);
      lookup_expect(32'h0002_0123, 64'h0000_0000_0002_0123, 1'b0, 1'b1, 0, "R6");

      // R10: enable and look up in the same cycle
      wr(4, 0, 32'h0000_0030);
      wr(4, 1, 32'h0000_0001);
      @(negedge clk);
      cur_req = "R10";
      cfg_we = 1'b1; cfg_win = 3'd4; cfg_sel = 2'd3; cfg_wdata = 32'h8004_4000;
      lk_valid = 1'b1; lk_addr = 32'h0003_0010;
      @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
      chk(rsp_miss === 1'b1 && rsp_addr === 64'h3_0010, "R10", rsp_addr, 64'h3_0010);
      lookup_expect(32'h0003_0010, 64'h0000_0000_0000_1010, 1'b0, 1'b0, 4, "R10");

      // Random mix checked against the model every cycle (R2..R10)
      cur_req = "R3";
      for (int n = 0; n < 4000; n++) begin
         logic [19:0] pb;
         @(negedge clk);
         case ($urandom % 4)
            0: pb = 20'h80000;
            1: pb = 20'h81234;
            2: pb = 20'h00010;
            default: pb = 20'($urandom);
         endcase
         cfg_we  = (($urandom % 4) == 0);
         cfg_win = 3'($urandom);
         cfg_sel = 2'($urandom);
         if (cfg_sel == 2'd3)
            cfg_wdata = {1'($urandom), 11'h0, (($urandom % 2) == 1) ? 8'h88 : 8'h44,
                         6'h0, 6'($urandom % 34)};
         else if (cfg_sel == 2'd0)
            cfg_wdata = {12'h0, pb};
         else
            cfg_wdata = $urandom;
         lk_valid = (($urandom % 3) != 0);
         lk_addr  = {pb, 12'($urandom)} ^ ((($urandom % 2) == 1) ? (32'h1 << ($urandom % 32)) : 32'h0);
      end
      @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
      repeat (3) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule